// File: doc/BRIEF.md
# Decimal-Capable 8-bit ALU

A purely combinational 8-bit arithmetic and logic unit for an accumulator-style processor core. Each evaluation takes the accumulator, an operand byte, a 4-bit operation code and the current carry and decimal-mode flags. It returns the result byte and the next values of the negative (N), zero (Z), carry (C) and overflow (V) flags. Each flag comes with an update-enable, so the surrounding status register only changes the flags that the operation defines.

Add-with-carry and subtract-with-borrow work in either plain binary or packed BCD. In decimal mode the result byte is nibble-adjusted, but N, Z and V still describe the unadjusted binary sum or difference. The decimal carry-out rule differs between add and subtract. Shifts, rotates, increment and decrement act on the operand input, so the caller routes either a memory byte or the accumulator there. Compare and bit test return the accumulator unchanged and only produce flags.

Top module: `dec_alu`

## Requirements
- R1: Op code 0 (add), decimal flag low: result = (A + B + Cin) mod 256; C = bit 8 of that 9-bit sum; V = 1 when A and B share bit 7 and the result's bit 7 differs from A's; all four enables are 1.
- R2: Op code 0 with the decimal flag high: lo = A[3:0]+B[3:0]+Cin and hi = A[7:4]+B[7:4]. When lo > 9, lo gains 6 and hi gains 1; then when hi > 9, hi gains 6. The result is {hi[3:0], lo[3:0]} and C = bit 4 of the adjusted hi.
- R3: Op code 1 (subtract), decimal flag low: result = (A - B - (1-Cin)) mod 256; C = 1 when that difference does not go below zero; V = 1 when A and B differ in bit 7 and the result's bit 7 differs from A's; all four enables are 1.
- R4: Op code 1 with the decimal flag high: lo = A[3:0]-B[3:0]-(1-Cin) and hi = A[7:4]-B[7:4]. When lo has bit 4 set, lo loses 6 and hi loses 1; then when hi has bit 4 set, hi loses 6. The result is {hi[3:0], lo[3:0]} and C follows the binary rule of R3.
- R5: In decimal add and decimal subtract, N, Z and V come from the binary sum or difference, not from the adjusted result.
- R6: Op codes 2, 3 and 4 give A AND B, A OR B and A XOR B. N and Z are taken from the result, and only nEn and zEn are 1.
- R7: Op codes 5 to 8 act on B. Code 5 shifts left with C = B[7] and a 0 shifted in. Code 6 shifts right with C = B[0] and a 0 shifted in. Code 7 rotates left with Cin entering bit 0. Code 8 rotates right with Cin entering bit 7. N and Z are taken from the result; nEn, zEn and cEn are 1.
- R8: Op code 9 (compare): the result equals A; C = 1 when A >= B unsigned; N and Z come from (A - B) mod 256; vEn = 0.
- R9: Op codes 10 and 11 give (B + 1) mod 256 and (B - 1) mod 256, whatever the decimal flag. N and Z are taken from the result; only nEn and zEn are 1.
- R10: Op code 12 (bit test): the result equals A; N = B[7]; V = B[6]; Z = 1 when (A AND B) is zero; nEn, zEn and vEn are 1 and cEn is 0.
- R11: Op codes 13 to 15 return A with all four enables at 0.
- R12: A flag output whose enable is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| accIn | input | 8 | Accumulator value |
| opndIn | input | 8 | Operand byte |
| opSel | input | 4 | Operation code |
| carryIn | input | 1 | Current carry flag |
| decimalIn | input | 1 | Current decimal-mode flag |
| resultOut | output | 8 | Result byte |
| nOut | output | 1 | Next N flag |
| zOut | output | 1 | Next Z flag |
| cOut | output | 1 | Next C flag |
| vOut | output | 1 | Next V flag |
| nEn | output | 1 | Update-enable for N |
| zEn | output | 1 | Update-enable for Z |
| cEn | output | 1 | Update-enable for C |
| vEn | output | 1 | Update-enable for V |

## Verification
The block holds no state, so a wrong strobe from the decoder or a wrong nibble correction shows at the ports in the same evaluation that presents the inputs. A fault in the decimal correction often appears only for a few digit combinations, such as a low nibble sum of exactly 10 or a high nibble that wraps after the borrow. For that reason every operand pair is compared for add and subtract, with both carry-in values and both modes. A flag sourced from the adjusted result instead of the binary one shows at once on cases such as 0x99 + 0x01.

// File: rtl/dec_alu_pkg.sv
package dec_alu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADC = 4'd0, OP_SBC = 4'd1, OP_AND = 4'd2, OP_ORA = 4'd3,
    OP_EOR = 4'd4, OP_SHL = 4'd5, OP_SHR = 4'd6, OP_ROL = 4'd7,
    OP_ROR = 4'd8, OP_CMP = 4'd9, OP_INC = 4'd10, OP_DEC = 4'd11,
    OP_BIT = 4'd12
  } aluOp_e;

  typedef enum logic [1:0] {Y_OPND, Y_INV, Y_ZERO, Y_ONES} addY_e;
  typedef enum logic [1:0] {CI_FLAG, CI_ONE, CI_ZERO} cinSel_e;
  typedef enum logic [2:0] {SRC_ACC, SRC_SUM, SRC_BCD, SRC_LOGIC, SRC_SHIFT} src_e;
  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR} logic_e;
  typedef enum logic [1:0] {SH_LEFT, SH_RIGHT, SH_ROL, SH_ROR} shift_e;
  typedef enum logic [1:0] {NZ_SUM, NZ_RESULT, NZ_BIT} nzSrc_e;
  typedef enum logic [1:0] {C_NONE, C_SUM, C_BCD, C_SHIFT} cSrc_e;

  typedef struct packed {
    logic    xFromOpnd;
    addY_e   ySel;
    cinSel_e cinSel;
    logic    bcdSub;
    src_e    src;
    logic_e  lg;
    shift_e  sh;
    nzSrc_e  nzSrc;
    cSrc_e   cSrc;
    logic    vFromBit;
    logic    nEn;
    logic    zEn;
    logic    cEn;
    logic    vEn;
  } strobes_t;
endpackage

// File: rtl/dec_alu_ctrl.sv
module dec_alu_ctrl
  import dec_alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  input  logic            decimalIn,
  output strobes_t        strobes
);
  always_comb begin
    strobes = '0;
    strobes.src = SRC_ACC;
    case (opSel)
      OP_ADC, OP_SBC: begin
        strobes.ySel   = (opSel == OP_SBC) ? Y_INV : Y_OPND;
        strobes.cinSel = CI_FLAG;
        strobes.bcdSub = (opSel == OP_SBC);
        strobes.src    = decimalIn ? SRC_BCD : SRC_SUM;
        strobes.nzSrc  = NZ_SUM;
        strobes.cSrc   = (decimalIn && opSel == OP_ADC) ? C_BCD : C_SUM;
        strobes.nEn = 1'b1; strobes.zEn = 1'b1;
        strobes.cEn = 1'b1; strobes.vEn = 1'b1;
      end
      OP_AND, OP_ORA, OP_EOR: begin
        strobes.src   = SRC_LOGIC;
        strobes.lg    = (opSel == OP_AND) ? LG_AND :
                        (opSel == OP_ORA) ? LG_OR : LG_XOR;
        strobes.nzSrc = NZ_RESULT;
        strobes.nEn = 1'b1; strobes.zEn = 1'b1;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        strobes.src   = SRC_SHIFT;
        strobes.sh    = (opSel == OP_SHL) ? SH_LEFT :
                        (opSel == OP_SHR) ? SH_RIGHT :
                        (opSel == OP_ROL) ? SH_ROL : SH_ROR;
        strobes.nzSrc = NZ_RESULT;
        strobes.cSrc  = C_SHIFT;
        strobes.nEn = 1'b1; strobes.zEn = 1'b1; strobes.cEn = 1'b1;
      end
      OP_CMP: begin
        strobes.ySel   = Y_INV;
        strobes.cinSel = CI_ONE;
        strobes.src    = SRC_ACC;
        strobes.nzSrc  = NZ_SUM;
        strobes.cSrc   = C_SUM;
        strobes.nEn = 1'b1; strobes.zEn = 1'b1; strobes.cEn = 1'b1;
      end
      OP_INC, OP_DEC: begin
        strobes.xFromOpnd = 1'b1;
        strobes.ySel      = (opSel == OP_INC) ? Y_ZERO : Y_ONES;
        strobes.cinSel    = (opSel == OP_INC) ? CI_ONE : CI_ZERO;
        strobes.src       = SRC_SUM;
        strobes.nzSrc     = NZ_SUM;
        strobes.nEn = 1'b1; strobes.zEn = 1'b1;
      end
      OP_BIT: begin
        strobes.src      = SRC_ACC;
        strobes.nzSrc    = NZ_BIT;
        strobes.vFromBit = 1'b1;
        strobes.nEn = 1'b1; strobes.zEn = 1'b1; strobes.vEn = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dec_alu_bcd.sv
module dec_alu_bcd
  import dec_alu_pkg::*;
(
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] opndIn,
  input  logic              carryIn,
  input  logic              isSub,
  output logic [DATA_W-1:0] adjOut,
  output logic              carryOut
);
  localparam int DIG_W = NIB_W + 2;
  localparam logic [DIG_W-1:0] DIG_MAX = DIG_W'(9);
  localparam logic [DIG_W-1:0] DIG_FIX = DIG_W'(6);
  localparam logic [DIG_W-1:0] DIG_ONE = DIG_W'(1);

  logic [DIG_W-1:0] aLo, aHi, bLo, bHi, lo, hi;

  always_comb begin
    aLo = {2'b00, accIn[NIB_W-1:0]};
    aHi = {2'b00, accIn[DATA_W-1:NIB_W]};
    bLo = {2'b00, opndIn[NIB_W-1:0]};
    bHi = {2'b00, opndIn[DATA_W-1:NIB_W]};
    if (!isSub) begin
      lo = aLo + bLo + {{(DIG_W-1){1'b0}}, carryIn};
      hi = aHi + bHi;
      if (lo > DIG_MAX) begin
        lo = lo + DIG_FIX;
        hi = hi + DIG_ONE;
      end
      if (hi > DIG_MAX) hi = hi + DIG_FIX;
    end else begin
      lo = aLo - bLo - {{(DIG_W-1){1'b0}}, ~carryIn};
      hi = aHi - bHi;
      if (lo[NIB_W]) begin
        lo = lo - DIG_FIX;
        hi = hi - DIG_ONE;
      end
      if (hi[NIB_W]) hi = hi - DIG_FIX;
    end
    adjOut   = {hi[NIB_W-1:0], lo[NIB_W-1:0]};
    carryOut = hi[NIB_W];
  end
endmodule

// File: rtl/dec_alu_path.sv
module dec_alu_path
  import dec_alu_pkg::*;
(
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] opndIn,
  input  logic              carryIn,
  input  strobes_t          strobes,
  output logic [DATA_W-1:0] resultOut,
  output logic              nOut,
  output logic              zOut,
  output logic              cOut,
  output logic              vOut
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] addX, addY, logicRes, shiftRes, bcdRes;
  logic [DATA_W:0]   sum;
  logic              cinBit, sumV, shiftC, bcdC;
  logic              nRaw, zRaw, cRaw, vRaw;

  dec_alu_bcd u_bcd (
    .accIn    (accIn),
    .opndIn   (opndIn),
    .carryIn  (carryIn),
    .isSub    (strobes.bcdSub),
    .adjOut   (bcdRes),
    .carryOut (bcdC)
  );

  always_comb begin
    addX = strobes.xFromOpnd ? opndIn : accIn;
    case (strobes.ySel)
      Y_OPND:  addY = opndIn;
      Y_INV:   addY = ~opndIn;
      Y_ZERO:  addY = '0;
      default: addY = '1;
    endcase
    case (strobes.cinSel)
      CI_FLAG: cinBit = carryIn;
      CI_ONE:  cinBit = 1'b1;
      default: cinBit = 1'b0;
    endcase
    sum  = {1'b0, addX} + {1'b0, addY} + {{DATA_W{1'b0}}, cinBit};
    sumV = (addX[MSB] == addY[MSB]) && (sum[MSB] != addX[MSB]);
  end

  always_comb begin
    case (strobes.lg)
      LG_AND:  logicRes = accIn & opndIn;
      LG_OR:   logicRes = accIn | opndIn;
      default: logicRes = accIn ^ opndIn;
    endcase
  end

  always_comb begin
    case (strobes.sh)
      SH_LEFT:  begin shiftRes = {opndIn[MSB-1:0], 1'b0};    shiftC = opndIn[MSB]; end
      SH_RIGHT: begin shiftRes = {1'b0, opndIn[MSB:1]};      shiftC = opndIn[0];   end
      SH_ROL:   begin shiftRes = {opndIn[MSB-1:0], carryIn}; shiftC = opndIn[MSB]; end
      default:  begin shiftRes = {carryIn, opndIn[MSB:1]};   shiftC = opndIn[0];   end
    endcase
  end

  always_comb begin
    case (strobes.src)
      SRC_SUM:   resultOut = sum[DATA_W-1:0];
      SRC_BCD:   resultOut = bcdRes;
      SRC_LOGIC: resultOut = logicRes;
      SRC_SHIFT: resultOut = shiftRes;
      default:   resultOut = accIn;
    endcase

    case (strobes.nzSrc)
      NZ_SUM:    begin nRaw = sum[MSB];       zRaw = (sum[DATA_W-1:0] == '0); end
      NZ_RESULT: begin nRaw = resultOut[MSB]; zRaw = (resultOut == '0);       end
      default:   begin nRaw = opndIn[MSB];    zRaw = ((accIn & opndIn) == '0); end
    endcase

    case (strobes.cSrc)
      C_SUM:   cRaw = sum[DATA_W];
      C_BCD:   cRaw = bcdC;
      C_SHIFT: cRaw = shiftC;
      default: cRaw = 1'b0;
    endcase

    vRaw = strobes.vFromBit ? opndIn[MSB-1] : sumV;

    nOut = nRaw & strobes.nEn;
    zOut = zRaw & strobes.zEn;
    cOut = cRaw & strobes.cEn;
    vOut = vRaw & strobes.vEn;
  end
endmodule

// File: rtl/dec_alu.sv
module dec_alu
  import dec_alu_pkg::*;
(
  input  logic [7:0] accIn,
  input  logic [7:0] opndIn,
  input  logic [3:0] opSel,
  input  logic       carryIn,
  input  logic       decimalIn,
  output logic [7:0] resultOut,
  output logic       nOut,
  output logic       zOut,
  output logic       cOut,
  output logic       vOut,
  output logic       nEn,
  output logic       zEn,
  output logic       cEn,
  output logic       vEn
);
  strobes_t strobes;

  dec_alu_ctrl u_ctrl (
    .opSel     (opSel),
    .decimalIn (decimalIn),
    .strobes   (strobes)
  );

  dec_alu_path u_path (
    .accIn     (accIn),
    .opndIn    (opndIn),
    .carryIn   (carryIn),
    .strobes   (strobes),
    .resultOut (resultOut),
    .nOut      (nOut),
    .zOut      (zOut),
    .cOut      (cOut),
    .vOut      (vOut)
  );

  assign nEn = strobes.nEn;
  assign zEn = strobes.zEn;
  assign cEn = strobes.cEn;
  assign vEn = strobes.vEn;
endmodule

// File: rtl/dec_alu_chk.sv
module dec_alu_chk (
  input logic [7:0] accIn,
  input logic [7:0] opndIn,
  input logic [3:0] opSel,
  input logic       carryIn,
  input logic       decimalIn,
  input logic [7:0] resultOut,
  input logic       nOut,
  input logic       zOut,
  input logic       cOut,
  input logic       vOut,
  input logic       nEn,
  input logic       zEn,
  input logic       cEn,
  input logic       vEn
);
  logic [8:0] addWide, subNeed;
  logic [7:0] subByte, andByte, incByte;

  always_comb begin
    addWide = {1'b0, accIn} + {1'b0, opndIn} + {8'b0, carryIn};
    subNeed = {1'b0, opndIn} + {8'b0, ~carryIn};
    subByte = accIn - opndIn - {7'b0, ~carryIn};
    andByte = accIn & opndIn;
    incByte = opndIn + 8'd1;

    if (opSel == 4'd0 && !decimalIn)
      AST_ADD_BINARY: assert ({cOut, resultOut} == addWide) else $error("add mismatch"); // R1
    if (opSel == 4'd1)
      AST_SUB_CARRY: assert (cOut == ({1'b0, accIn} >= subNeed)) else $error("sub carry"); // R3
    if (opSel == 4'd0 && decimalIn)
      AST_DEC_ADD_Z: assert (zOut == (addWide[7:0] == 8'd0)) else $error("dec add Z"); // R5
    if (opSel == 4'd1 && decimalIn)
      AST_DEC_SUB_N: assert (nOut == subByte[7]) else $error("dec sub N"); // R5
    if (opSel == 4'd9)
      AST_CMP_KEEPS_ACC: assert (resultOut == accIn && !vEn && cOut == (accIn >= opndIn)) else $error("cmp"); // R8
    if (opSel == 4'd10)
      AST_INC_WRAP: assert (resultOut == incByte && !cEn && !vEn) else $error("inc"); // R9
    if (opSel == 4'd12)
      AST_BIT_FLAGS: assert (nOut == opndIn[7] && vOut == opndIn[6] && zOut == (andByte == 8'd0) && resultOut == accIn) else $error("bit"); // R10
    if (opSel >= 4'd13)
      AST_IDLE_CODES: assert (resultOut == accIn && {nEn, zEn, cEn, vEn} == 4'b0000) else $error("idle"); // R11
    AST_GATED_FLAGS: assert ((nEn || !nOut) && (zEn || !zOut) && (cEn || !cOut) && (vEn || !vOut)) else $error("gating"); // R12
  end
endmodule

bind dec_alu dec_alu_chk u_dec_alu_chk (
  .accIn(accIn), .opndIn(opndIn), .opSel(opSel), .carryIn(carryIn),
  .decimalIn(decimalIn), .resultOut(resultOut), .nOut(nOut), .zOut(zOut),
  .cOut(cOut), .vOut(vOut), .nEn(nEn), .zEn(zEn), .cEn(cEn), .vEn(vEn)
);

// File: tb/dec_alu_bench.sv
`timescale 1ns/100ps
module dec_alu_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] accIn, opndIn, resultOut;
  logic [3:0] opSel;
  logic carryIn, decimalIn;
  logic nOut, zOut, cOut, vOut, nEn, zEn, cEn, vEn;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  dec_alu u_dec_alu (
    .accIn(accIn), .opndIn(opndIn), .opSel(opSel), .carryIn(carryIn),
    .decimalIn(decimalIn), .resultOut(resultOut), .nOut(nOut), .zOut(zOut),
    .cOut(cOut), .vOut(vOut), .nEn(nEn), .zEn(zEn), .cEn(cEn), .vEn(vEn)
  );

  // Packs {result, nEn, zEn, cEn, vEn, N, Z, C, V}
  function automatic logic [15:0] refAlu(int op, int a, int b, int c, int d);
    int r, bin, lo, hi;
    bit n, z, cy, v, ne, ze, ce, ve;
    r = a; n = 0; z = 0; cy = 0; v = 0; ne = 0; ze = 0; ce = 0; ve = 0;
    case (op)
      0: begin
        bin = a + b + c;
        v = ((~(a ^ b)) & (a ^ bin) & 'h80) != 0;
        cy = bin > 'hff;
        r = bin & 'hff;
        if (d != 0) begin
          lo = (a & 15) + (b & 15) + c;
          hi = (a >> 4) + (b >> 4);
          if (lo > 9) begin lo += 6; hi += 1; end
          if (hi > 9) hi += 6;
          r = ((lo & 15) | (hi << 4)) & 'hff;
          cy = (hi & 16) != 0;
        end
        n = ((bin >> 7) & 1) != 0; z = (bin & 'hff) == 0;
        ne = 1; ze = 1; ce = 1; ve = 1;
      end
      1: begin
        bin = a - b - (1 - c);
        v = ((a ^ b) & (a ^ bin) & 'h80) != 0;
        cy = bin >= 0;
        r = bin & 'hff;
        if (d != 0) begin
          lo = (a & 15) - (b & 15) - (1 - c);
          hi = (a >> 4) - (b >> 4);
          if ((lo & 16) != 0) begin lo -= 6; hi -= 1; end
          if ((hi & 16) != 0) hi -= 6;
          r = ((lo & 15) | (hi << 4)) & 'hff;
        end
        n = ((bin >> 7) & 1) != 0; z = (bin & 'hff) == 0;
        ne = 1; ze = 1; ce = 1; ve = 1;
      end
      2, 3, 4: begin
        r = (op == 2) ? (a & b) : (op == 3) ? (a | b) : (a ^ b);
        n = ((r >> 7) & 1) != 0; z = r == 0; ne = 1; ze = 1;
      end
      5, 6, 7, 8: begin
        case (op)
          5: begin r = (b << 1) & 'hff; cy = ((b >> 7) & 1) != 0; end
          6: begin r = b >> 1; cy = (b & 1) != 0; end
          7: begin r = ((b << 1) | c) & 'hff; cy = ((b >> 7) & 1) != 0; end
          default: begin r = (b >> 1) | (c << 7); cy = (b & 1) != 0; end
        endcase
        n = ((r >> 7) & 1) != 0; z = r == 0; ne = 1; ze = 1; ce = 1;
      end
      9: begin
        bin = (a - b) & 'hff;
        cy = a >= b; n = ((bin >> 7) & 1) != 0; z = bin == 0;
        ne = 1; ze = 1; ce = 1;
      end
      10, 11: begin
        r = (op == 10) ? ((b + 1) & 'hff) : ((b + 255) & 'hff);
        n = ((r >> 7) & 1) != 0; z = r == 0; ne = 1; ze = 1;
      end
      12: begin
        n = ((b >> 7) & 1) != 0; v = ((b >> 6) & 1) != 0; z = (a & b) == 0;
        ne = 1; ze = 1; ve = 1;
      end
      default: ;
    endcase
    refAlu = {r[7:0], ne, ze, ce, ve, n & ne, z & ze, cy & ce, v & ve};
  endfunction

  function automatic string reqOf(int op, int d);
    case (op)
      0: reqOf = (d != 0) ? "R2" : "R1";
      1: reqOf = (d != 0) ? "R4" : "R3";
      2, 3, 4: reqOf = "R6";
      5, 6, 7, 8: reqOf = "R7";
      9: reqOf = "R8";
      10, 11: reqOf = "R9";
      12: reqOf = "R10";
      default: reqOf = "R11";
    endcase
  endfunction

  // Drives at x.2 ns, samples at x.7 ns: clear of clock edges on whole ns.
  task automatic applyCheck(int op, int a, int b, int c, int d, string tag);
    logic [15:0] exp, got;
    opSel = op[3:0]; accIn = a[7:0]; opndIn = b[7:0];
    carryIn = c[0]; decimalIn = d[0];
    #0.5;
    exp = refAlu(op, a, b, c, d);
    got = {resultOut, nEn, zEn, cEn, vEn, nOut, zOut, cOut, vOut};
    compared++;
    if (got !== exp) begin
      mismatched++;
      if (mismatched <= 20)
        $display("FAIL %s op=%0d a=%h b=%h c=%0d d=%0d actual=%h expected=%h",
                 tag, op, a, b, c, d, got, exp);
    end
    #0.5;
  endtask

  initial begin
    accIn = 0; opndIn = 0; opSel = 0; carryIn = 0; decimalIn = 0;
    @(posedge clk);
    #0.2;
    // Quiet state: unused code returns A with no flag updates (R11)
    applyCheck(13, 8'h5a, 8'h00, 1, 1, "R11");
    applyCheck(15, 8'h80, 8'hff, 0, 0, "R11");
    // Decimal corners
    applyCheck(0, 8'h99, 8'h01, 0, 1, "R2");   // 00, C=1
    applyCheck(0, 8'h99, 8'h01, 0, 1, "R5");   // Z from binary 9A -> 0
    applyCheck(0, 8'h58, 8'h46, 1, 1, "R2");   // 05, C=1
    applyCheck(0, 8'h09, 8'h01, 0, 1, "R2");   // low digit carry
    applyCheck(1, 8'h00, 8'h01, 1, 1, "R4");   // 99, C=0
    applyCheck(1, 8'h46, 8'h12, 1, 1, "R4");   // 34
    applyCheck(1, 8'h40, 8'h13, 0, 1, "R4");   // 26
    applyCheck(1, 8'h80, 8'h01, 1, 1, "R5");   // V from binary
    // Binary corners
    applyCheck(0, 8'h7f, 8'h01, 0, 0, "R1");
    applyCheck(0, 8'hff, 8'h00, 1, 0, "R1");
    applyCheck(1, 8'h80, 8'h01, 1, 0, "R3");
    applyCheck(9, 8'h10, 8'h10, 0, 0, "R8");
    applyCheck(9, 8'h0f, 8'h10, 1, 0, "R8");
    applyCheck(10, 8'h00, 8'hff, 0, 1, "R9");
    applyCheck(11, 8'h00, 8'h00, 1, 1, "R9");
    applyCheck(12, 8'h3c, 8'hc3, 0, 0, "R10");
    applyCheck(7, 8'h00, 8'h80, 1, 0, "R7");
    applyCheck(8, 8'h00, 8'h01, 1, 0, "R7");
    applyCheck(2, 8'hff, 8'hff, 1, 0, "R12");  // carry in, C must read 0
    applyCheck(4, 8'h55, 8'h55, 0, 0, "R6");
    // Full sweep of add and subtract, both carries and both modes
    for (int op = 0; op < 2; op++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 2; c++)
          for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
              applyCheck(op, a, b, c, d, reqOf(op, d));
    // Random mix over every code
    void'($urandom(32'h0d0ca1));
    for (int i = 0; i < 20000; i++) begin
      int op, a, b, c, d;
      op = int'($urandom % 16); a = int'($urandom % 256); b = int'($urandom % 256);
      c = int'($urandom % 2); d = int'($urandom % 2);
      applyCheck(op, a, b, c, d, reqOf(op, d));
    end
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule